// File: doc/BRIEF.md
# Device Power State Access Gate

This block keeps the power state of a host controller function and gates what the rest of the function may do in each state. Only two states exist: full power and off. Configuration software writes a two-bit state field. While the function is off, every memory-mapped register access is refused with an abort completion. The function interrupt is held low, and wake inputs are reported on a power-management-event line instead.

When software moves the function from off back to full power, the block raises an internal reset pulse of a fixed length. The register space stays closed until that pulse ends. A debug port that shares the same register range is enabled only at full power, and only outside the reset pulse. In the full-power state every request is passed to the register file untouched, and the register file's completion is passed back untouched.

Top module: `dev_pwr_gate`

## Requirements
- R1: After reset the state field reads 00 (full power), the reset pulse is low, the event line is low and the debug enable is high.
- R2: A configuration write of 00 selects full power and a write of 11 selects off; the new value shows on `pwrState` in the cycle after the write.
- R3: Configuration writes of 01 or 10 are ignored, and the state field keeps its previous value.
- R4: While off, a request is not forwarded in its own cycle. In the next cycle a completion appears with the abort flag set and data of all ones.
- R5: At full power with no reset pulse, a request is forwarded in the same cycle. The register file's completion and data pass to the response port in the same cycle, with the abort flag low.
- R6: While off, `irqOut` stays low whatever `irqIn` does; at full power `irqOut` follows `irqIn` in the same cycle.
- R7: While off, a high wake input sets `pmeOut` in the next cycle; at full power `pmeOut` stays low.
- R8: A write of 00 while off raises `rstPulse` in the next cycle and holds it high for exactly RST_CYCLES cycles.
- R9: While `rstPulse` is high, requests are aborted as in R4 and the debug enable is low.
- R10: A write of 00 at full power, or a write of 11 while off, produces no reset pulse.
- R11: `dbgEn` is high exactly when the state is full power and no reset pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe for the state field |
| cfgWrState | input | 2 | Written state code (00 full power, 11 off) |
| pwrState | output | 2 | Current state field |
| mmioReq | input | 1 | Register access request from the host side |
| mmioFwd | output | 1 | Request forwarded to the register file |
| regRspValid | input | 1 | Completion from the register file |
| regRspData | input | DATA_W | Completion data from the register file |
| mmioRspValid | output | 1 | Completion to the host side |
| mmioRspAbort | output | 1 | Completion is a master abort |
| mmioRspData | output | DATA_W | Completion data to the host side |
| irqIn | input | 1 | Function interrupt request |
| irqOut | output | 1 | Gated function interrupt |
| wakeIn | input | WAKE_N | Wake event sources |
| pmeOut | output | 1 | Power-management event indication |
| rstPulse | output | 1 | Internal reset pulse for the function |
| dbgEn | output | 1 | Debug port enable |

## Verification
A wrong stored state shows at once on `pwrState`, `irqOut` and `dbgEn` in the cycle after the write. It also shows in the next request, through the forward strobe in the same cycle and the abort completion one cycle later. A miscounted reset pulse shows as a pulse length that differs from RST_CYCLES. It also shows as a request forwarded, or aborted, on the wrong side of the pulse's end. Wrong handling of the reserved codes, or of repeated writes of the same state, shows as a state change or a spurious pulse within one cycle.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  // Power state codes as seen by configuration software
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic inD0;       // full-power state
    logic rstActive;  // internal reset pulse running
    logic blockAcc;   // register space closed
  } gate_strb_t;

endpackage

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWrState,
  output logic [1:0] pwrState,
  output logic       rstPulse,
  output gate_strb_t strb
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  pstate_e          stateQ;
  logic [CNT_W-1:0] rstCnt;
  logic             wrLegal;
  logic             wakeRst;

  // Only the full-power and off codes are accepted
  assign wrLegal = cfgWrEn && (cfgWrState == PS_D0 || cfgWrState == PS_D3);
  assign wakeRst = wrLegal && (cfgWrState == PS_D0) && (stateQ == PS_D3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_D0;
      rstCnt <= '0;
    end else begin
      if (wrLegal) stateQ <= pstate_e'(cfgWrState);
      if (wakeRst) rstCnt <= CNT_LOAD;
      else if (rstCnt != '0) rstCnt <= rstCnt - 1'b1;
    end
  end

  assign rstPulse       = (rstCnt != '0);
  assign pwrState       = stateQ;
  assign strb.inD0      = (stateQ == PS_D0);
  assign strb.rstActive = rstPulse;
  assign strb.blockAcc  = (stateQ != PS_D0) || rstPulse;

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgWrState == PS_D1 || cfgWrState == PS_D2)) |=> $stable(stateQ)); // R3
  AST_WAKE_RST: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_D3 && cfgWrEn && cfgWrState == PS_D0) |=> (rstPulse && rstCnt == CNT_LOAD)); // R8
  AST_NO_SPURIOUS_RST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstPulse) |-> ($past(stateQ) == PS_D3)); // R10
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rstCnt <= CNT_LOAD); // R8

endmodule

// File: rtl/pwr_gate_dp.sv
module pwr_gate_dp
  import pwr_gate_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              WAKE_N    = 4,
  parameter logic [WAKE_N-1:0] WAKE_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strb_t        strb,
  input  logic              mmioReq,
  output logic              mmioFwd,
  input  logic              regRspValid,
  input  logic [DATA_W-1:0] regRspData,
  output logic              mmioRspValid,
  output logic              mmioRspAbort,
  output logic [DATA_W-1:0] mmioRspData,
  input  logic              irqIn,
  output logic              irqOut,
  input  logic [WAKE_N-1:0] wakeIn,
  output logic              pmeOut,
  output logic              dbgEn
);

  logic              abortQ;
  logic              pmeQ;
  logic [WAKE_N-1:0] wakeHit;

  // Per-source wake qualification, fixed by WAKE_MASK
  for (genvar i = 0; i < WAKE_N; i++) begin : g_wake
    if (WAKE_MASK[i]) begin : g_on
      assign wakeHit[i] = wakeIn[i];
    end else begin : g_off
      assign wakeHit[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortQ <= 1'b0;
      pmeQ   <= 1'b0;
    end else begin
      abortQ <= mmioReq && strb.blockAcc;
      pmeQ   <= !strb.inD0 && (|wakeHit);
    end
  end

  assign mmioFwd      = mmioReq && !strb.blockAcc;
  assign mmioRspValid = regRspValid || abortQ;
  assign mmioRspAbort = abortQ;
  assign mmioRspData  = abortQ ? '1 : regRspData;
  assign irqOut       = irqIn && strb.inD0;
  assign pmeOut       = pmeQ;
  assign dbgEn        = strb.inD0 && !strb.rstActive;

  AST_ABORT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (mmioReq && strb.blockAcc) |=> (mmioRspValid && mmioRspAbort)); // R4

endmodule

// File: rtl/dev_pwr_gate.sv
module dev_pwr_gate
  import pwr_gate_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                WAKE_N     = 4,
  parameter logic [WAKE_N-1:0] WAKE_MASK  = '1,
  parameter int                RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrState,
  output logic [1:0]        pwrState,
  input  logic              mmioReq,
  output logic              mmioFwd,
  input  logic              regRspValid,
  input  logic [DATA_W-1:0] regRspData,
  output logic              mmioRspValid,
  output logic              mmioRspAbort,
  output logic [DATA_W-1:0] mmioRspData,
  input  logic              irqIn,
  output logic              irqOut,
  input  logic [WAKE_N-1:0] wakeIn,
  output logic              pmeOut,
  output logic              rstPulse,
  output logic              dbgEn
);

  gate_strb_t strb;

  pwr_gate_ctrl #(.RST_CYCLES(RST_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrState(cfgWrState),
    .pwrState(pwrState), .rstPulse(rstPulse), .strb(strb)
  );

  pwr_gate_dp #(.DATA_W(DATA_W), .WAKE_N(WAKE_N), .WAKE_MASK(WAKE_MASK)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .mmioReq(mmioReq), .mmioFwd(mmioFwd),
    .regRspValid(regRspValid), .regRspData(regRspData),
    .mmioRspValid(mmioRspValid), .mmioRspAbort(mmioRspAbort), .mmioRspData(mmioRspData),
    .irqIn(irqIn), .irqOut(irqOut), .wakeIn(wakeIn), .pmeOut(pmeOut), .dbgEn(dbgEn)
  );

  AST_FWD_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_D3 || rstPulse) |-> !mmioFwd); // R4
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_D3) |-> !irqOut); // R6
  AST_DBG_GATE: assert property (@(posedge clk) disable iff (!rstN)
    dbgEn |-> (pwrState == PS_D0 && !rstPulse)); // R11
  AST_PME_SRC: assert property (@(posedge clk) disable iff (!rstN)
    pmeOut |-> ($past(pwrState) == PS_D3)); // R7

endmodule

// File: tb/test_dev_pwr_gate.sv
module test_dev_pwr_gate;

  localparam int DATA_W = 32;
  localparam int WAKE_N = 4;
  localparam int RST_CYCLES = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [1:0]        cfgWrState = 2'b00;
  logic [1:0]        pwrState;
  logic              mmioReq = 1'b0;
  logic              mmioFwd;
  logic              regRspValid = 1'b0;
  logic [DATA_W-1:0] regRspData = '0;
  logic              mmioRspValid;
  logic              mmioRspAbort;
  logic [DATA_W-1:0] mmioRspData;
  logic              irqIn = 1'b0;
  logic              irqOut;
  logic [WAKE_N-1:0] wakeIn = '0;
  logic              pmeOut;
  logic              rstPulse;
  logic              dbgEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dev_pwr_gate #(.DATA_W(DATA_W), .WAKE_N(WAKE_N), .RST_CYCLES(RST_CYCLES)) i_dev_pwr_gate (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrState(cfgWrState), .pwrState(pwrState),
    .mmioReq(mmioReq), .mmioFwd(mmioFwd), .regRspValid(regRspValid), .regRspData(regRspData),
    .mmioRspValid(mmioRspValid), .mmioRspAbort(mmioRspAbort), .mmioRspData(mmioRspData),
    .irqIn(irqIn), .irqOut(irqOut), .wakeIn(wakeIn), .pmeOut(pmeOut),
    .rstPulse(rstPulse), .dbgEn(dbgEn)
  );

  // {write, code, expected state, expected pulse}
  localparam logic [5:0] VEC [7] = '{
    {1'b1, 2'b01, 2'b00, 1'b0},  // R3 reserved code at full power
    {1'b1, 2'b11, 2'b11, 1'b0},  // R2 go off
    {1'b1, 2'b10, 2'b11, 1'b0},  // R3 reserved code while off
    {1'b1, 2'b11, 2'b11, 1'b0},  // R10 off again, no pulse
    {1'b1, 2'b00, 2'b00, 1'b1},  // R8 return to full power
    {1'b1, 2'b00, 2'b00, 1'b1},  // R10 repeat, pulse continues
    {1'b0, 2'b00, 2'b00, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    #1;
    check("R1 state", 32'(pwrState), 32'h0);
    check("R1 pulse", 32'(rstPulse), 32'h0);
    check("R1 pme", 32'(pmeOut), 32'h0);
    rstN = 1'b1;
    step();
    check("R1 dbgEn", 32'(dbgEn), 32'h1);

    irqIn = 1'b1;
    foreach (VEC[i]) begin
      cfgWrEn    = VEC[i][5];
      cfgWrState = VEC[i][4:3];
      step();
      cfgWrEn = 1'b0;
      #1;
      check("R2/R3 state", 32'(pwrState), 32'(VEC[i][2:1]));
      check("R8/R10 pulse", 32'(rstPulse), 32'(VEC[i][0]));
      check("R6 irq", 32'(irqOut), 32'(VEC[i][2:1] == 2'b00));
      check("R11 dbgEn", 32'(dbgEn), 32'(VEC[i][2:1] == 2'b00 && !VEC[i][0]));
    end
    while (rstPulse) step();
    check("R11 dbgEn after pulse", 32'(dbgEn), 32'h1);

    // R10: full-power write at full power
    cfgWrEn = 1'b1; cfgWrState = 2'b00;
    step();
    cfgWrEn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R10 no pulse", 32'(rstPulse), 32'h0);
      step();
    end

    // R5: pass-through at full power
    mmioReq = 1'b1; regRspValid = 1'b1; regRspData = 32'h1234_5678;
    #1;
    check("R5 fwd", 32'(mmioFwd), 32'h1);
    check("R5 rsp valid", 32'(mmioRspValid), 32'h1);
    check("R5 abort", 32'(mmioRspAbort), 32'h0);
    check("R5 data", mmioRspData, 32'h1234_5678);
    step();
    mmioReq = 1'b0; regRspValid = 1'b0;
    #1;
    check("R5 no abort after", 32'(mmioRspAbort), 32'h0);

    // R7: wake at full power
    wakeIn = 4'b0100;
    step();
    check("R7 pme at full power", 32'(pmeOut), 32'h0);
    cfgWrEn = 1'b1; cfgWrState = 2'b11;
    step();
    cfgWrEn = 1'b0;
    step();
    check("R7 pme while off", 32'(pmeOut), 32'h1);
    wakeIn = '0;
    step();
    check("R7 pme clears", 32'(pmeOut), 32'h0);

    // R6: interrupt masked while off
    irqIn = 1'b1;
    #1;
    check("R6 irq masked", 32'(irqOut), 32'h0);

    // R4: abort while off
    mmioReq = 1'b1;
    #1;
    check("R4 not forwarded", 32'(mmioFwd), 32'h0);
    step();
    mmioReq = 1'b0;
    #1;
    check("R4 rsp valid", 32'(mmioRspValid), 32'h1);
    check("R4 abort", 32'(mmioRspAbort), 32'h1);
    check("R4 data", mmioRspData, 32'hFFFF_FFFF);
    step();
    check("R4 single completion", 32'(mmioRspValid), 32'h0);

    // R8/R9: return to full power
    cfgWrEn = 1'b1; cfgWrState = 2'b00;
    #1;
    check("R8 no pulse yet", 32'(rstPulse), 32'h0);
    step();
    cfgWrEn = 1'b0;
    check("R8 pulse starts", 32'(rstPulse), 32'h1);
    check("R9 dbg off", 32'(dbgEn), 32'h0);
    check("R6 irq follows", 32'(irqOut), 32'h1);
    mmioReq = 1'b1;
    #1;
    check("R9 not forwarded", 32'(mmioFwd), 32'h0);
    n = 1;
    step();
    mmioReq = 1'b0;
    #1;
    check("R9 abort", 32'(mmioRspAbort), 32'h1);
    while (rstPulse && n < 100) begin
      n++;
      step();
    end
    check("R8 pulse length", 32'(n), 32'(RST_CYCLES));
    mmioReq = 1'b1;
    #1;
    check("R9 open after pulse", 32'(mmioFwd), 32'h1);
    mmioReq = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule